// File: doc/BRIEF.md
# Subtractive Multi-Tag Index Unit

This unit forms effective addresses for a machine whose instructions carry an address field and a small tag field. It holds seven index registers. For each request it chooses an index value from them according to the tag and the current addressing mode, subtracts that value from the address field, and presents the result one cycle later. A tag of zero applies no index.

Two addressing modes exist. In single-register mode each non-zero tag value names one of the seven registers. In multiple-tag mode, kept for compatibility with older code, each tag bit names one register on its own: bit 0 names register 1, bit 1 names register 2 and bit 2 names register 4. The registers named by set tag bits are combined with a bitwise OR. The mode is a stored flag. It comes out of reset in multiple-tag mode and changes only when a command pulse arrives. Software loads the index registers through a numbered write port and reads them back through a combinational read port.

Top module: `idx_ea_unit`

## Requirements
- R1: After reset, `ea_vld` is 0, `ea_addr` is 0, `mode_multi` is 1 (multiple-tag mode), and every index register reads back as 0.
- R2: A request with tag 000 yields `ea_addr` equal to `req_addr` in either mode.
- R3: When `mode_multi` is 0, a tag value n from 1 to 7 selects index register n, and `ea_addr` = `req_addr` − register n.
- R4: When `mode_multi` is 1, tag bit 0 selects register 1, bit 1 selects register 2 and bit 2 selects register 4. Registers 3, 5, 6 and 7 never take part.
- R5: When `mode_multi` is 1 and more than one tag bit is set, the index value is the bitwise OR of the selected registers.
- R6: The subtraction wraps modulo 2^15. An index larger than the address gives `req_addr` − index + 32768.
- R7: A cycle with `wr_en` high and `wr_num` from 1 to 7 loads `wr_data` into that register at the clock edge. `rd_data` shows the register numbered by `rd_num` combinationally, and `rd_num` 0 reads as 0.
- R8: A write with `wr_num` 0 changes no index register.
- R9: A pulse on `cmd_single` alone clears `mode_multi`. A pulse on `cmd_multi` alone sets it. When both or neither are high, the flag holds its value.
- R10: `ea_vld` equals `req_vld` delayed by one cycle. `ea_addr` updates only at the edge that samples a request and otherwise holds its value.
- R11: A request uses the register contents and the mode as they were before any write or mode command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Address request strobe |
| req_addr | input | 15 | Address field of the instruction |
| req_tag | input | 3 | Tag field of the instruction |
| ea_vld | output | 1 | Effective address valid, one cycle after the strobe |
| ea_addr | output | 15 | Effective address |
| wr_en | input | 1 | Index register write enable |
| wr_num | input | 3 | Index register number to write (0 is ignored) |
| wr_data | input | 15 | Value to write |
| rd_num | input | 3 | Index register number to read |
| rd_data | output | 15 | Contents of the register named by rd_num |
| cmd_single | input | 1 | Pulse: enter single-register mode |
| cmd_multi | input | 1 | Pulse: enter multiple-tag mode |
| mode_multi | output | 1 | 1 in multiple-tag mode, 0 in single-register mode |

## Verification
A request and a register load can land in the same cycle, and so can a request and a mode command. The bench provokes both. It writes the very register a same-cycle request selects, and it issues `cmd_multi` alongside a single-mode request. A behavioural model compares every cycle and expects the request to see the old register value and the old mode. The new value or mode must then appear on the read port and the mode output at the next sample.

// File: rtl/idx_pkg.sv
package idx_pkg;

   typedef enum logic {
      IDX_MODE_SINGLE = 1'b0,
      IDX_MODE_MULTI  = 1'b1
   } idx_mode_e;

   // register number that tag bit k names in multiple-tag mode
   function automatic int multi_tag_reg(input int k);
      return 1 << k;
   endfunction

endpackage

// File: rtl/idx_regfile.sv
module idx_regfile #(
   parameter int AW = 15,
   parameter int TW = 3,
   localparam int NREG = (1 << TW) - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [TW-1:0]            wr_num,
   input  logic [AW-1:0]            wr_data,
   input  logic [TW-1:0]            rd_num,
   output logic [AW-1:0]            rd_data,
   output logic [NREG:0][AW-1:0]    regs_o
);

   // slot 0 is a constant zero so that tag 0 needs no special case
   assign regs_o[0] = '0;

   for (genvar i = 1; i <= NREG; i++) begin : g_reg
      logic [AW-1:0] val_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q <= '0;
         end else if (wr_en && (wr_num == TW'(i))) begin
            val_q <= wr_data;
         end
      end
      assign regs_o[i] = val_q;
   end

   assign rd_data = regs_o[rd_num];

endmodule

// File: rtl/idx_mode_ctl.sv
module idx_mode_ctl
   import idx_pkg::*;
#(
   parameter bit MULTI_TAG_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_single,
   input  logic      cmd_multi,
   output idx_mode_e mode_o
);

   if (MULTI_TAG_EN) begin : g_switchable
      idx_mode_e mode_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q <= IDX_MODE_MULTI;
         end else if (cmd_single && !cmd_multi) begin
            mode_q <= IDX_MODE_SINGLE;
         end else if (cmd_multi && !cmd_single) begin
            mode_q <= IDX_MODE_MULTI;
         end
      end
      assign mode_o = mode_q;
   end else begin : g_fixed
      logic unused_cmds;
      assign unused_cmds = clk ^ rst_n ^ cmd_single ^ cmd_multi;
      assign mode_o = IDX_MODE_SINGLE;
   end

endmodule

// File: rtl/idx_select.sv
module idx_select
   import idx_pkg::*;
#(
   parameter int AW = 15,
   parameter int TW = 3,
   localparam int NREG = (1 << TW) - 1
) (
   input  logic [NREG:0][AW-1:0] regs_i,
   input  logic [TW-1:0]         tag_i,
   input  idx_mode_e             mode_i,
   output logic [AW-1:0]         index_o
);

   logic [AW-1:0] single_val;
   logic [TW:0][AW-1:0] or_chain;

   assign single_val  = regs_i[tag_i];
   assign or_chain[0] = '0;

   for (genvar k = 0; k < TW; k++) begin : g_tagbit
      localparam int RN = multi_tag_reg(k);
      assign or_chain[k+1] = or_chain[k] | (regs_i[RN] & {AW{tag_i[k]}});
   end

   assign index_o = (mode_i == IDX_MODE_MULTI) ? or_chain[TW] : single_val;

endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
   import idx_pkg::*;
#(
   parameter int AW           = 15,
   parameter int TW           = 3,
   parameter bit MULTI_TAG_EN = 1'b1,
   localparam int NREG = (1 << TW) - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_vld,
   input  logic [AW-1:0] req_addr,
   input  logic [TW-1:0] req_tag,
   output logic          ea_vld,
   output logic [AW-1:0] ea_addr,
   input  logic          wr_en,
   input  logic [TW-1:0] wr_num,
   input  logic [AW-1:0] wr_data,
   input  logic [TW-1:0] rd_num,
   output logic [AW-1:0] rd_data,
   input  logic          cmd_single,
   input  logic          cmd_multi,
   output logic          mode_multi
);

   if (AW < 2 || AW > 32) begin : g_bad_aw
      $error("idx_ea_unit: AW must lie in 2..32");
   end
   if (TW < 2 || TW > 4) begin : g_bad_tw
      $error("idx_ea_unit: TW must lie in 2..4");
   end

   logic [NREG:0][AW-1:0] regs;
   logic [AW-1:0]         index_val;
   idx_mode_e             mode;
   logic                  ea_vld_q;
   logic [AW-1:0]         ea_addr_q;

   idx_regfile #(.AW(AW), .TW(TW)) i_regfile (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_num  (wr_num),
      .wr_data (wr_data),
      .rd_num  (rd_num),
      .rd_data (rd_data),
      .regs_o  (regs)
   );

   idx_mode_ctl #(.MULTI_TAG_EN(MULTI_TAG_EN)) i_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_single (cmd_single),
      .cmd_multi  (cmd_multi),
      .mode_o     (mode)
   );

   idx_select #(.AW(AW), .TW(TW)) i_select (
      .regs_i  (regs),
      .tag_i   (req_tag),
      .mode_i  (mode),
      .index_o (index_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_vld_q  <= 1'b0;
         ea_addr_q <= '0;
      end else begin
         ea_vld_q <= req_vld;
         if (req_vld) begin
            ea_addr_q <= req_addr - index_val;
         end
      end
   end

   assign ea_vld     = ea_vld_q;
   assign ea_addr    = ea_addr_q;
   assign mode_multi = (mode == IDX_MODE_MULTI);

endmodule

// File: rtl/idx_ea_unit_chk.sv
module idx_ea_unit_chk #(
   parameter int AW = 15,
   parameter int TW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_vld,
   input logic [AW-1:0] req_addr,
   input logic [TW-1:0] req_tag,
   input logic          ea_vld,
   input logic [AW-1:0] ea_addr,
   input logic [TW-1:0] rd_num,
   input logic [AW-1:0] rd_data,
   input logic          cmd_single,
   input logic          cmd_multi,
   input logic          mode_multi
);

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_EA_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (ea_vld == $past(req_vld)));                                  // R10
   AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(req_vld)) |-> $stable(ea_addr));                        // R10
   AST_NOTAG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(req_vld) && ($past(req_tag) == '0)) |-> (ea_addr == $past(req_addr))); // R2
   AST_MODE_TO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(cmd_single && !cmd_multi)) |-> !mode_multi);             // R9
   AST_MODE_TO_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(cmd_multi && !cmd_single)) |-> mode_multi);              // R9
   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(cmd_multi == cmd_single)) |-> $stable(mode_multi));      // R9
   AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_num == '0) |-> (rd_data == '0));                                       // R7

endmodule

bind idx_ea_unit idx_ea_unit_chk #(.AW(AW), .TW(TW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_vld    (req_vld),
   .req_addr   (req_addr),
   .req_tag    (req_tag),
   .ea_vld     (ea_vld),
   .ea_addr    (ea_addr),
   .rd_num     (rd_num),
   .rd_data    (rd_data),
   .cmd_single (cmd_single),
   .cmd_multi  (cmd_multi),
   .mode_multi (mode_multi)
);

// File: tb/test_idx_ea_unit.sv
`timescale 1ns/1ps
module test_idx_ea_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [14:0] req_addr = '0;
   logic [2:0]  req_tag = '0;
   logic        ea_vld;
   logic [14:0] ea_addr;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_num = '0;
   logic [14:0] wr_data = '0;
   logic [2:0]  rd_num = '0;
   logic [14:0] rd_data;
   logic        cmd_single = 1'b0;
   logic        cmd_multi = 1'b0;
   logic        mode_multi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   int xr [8];
   bit m_multi;
   bit m_vld;
   int m_ea;

   always #2.5 clk = ~clk;

   idx_ea_unit i_idx_ea_unit (
      .clk(clk), .rst_n(rst_n),
      .req_vld(req_vld), .req_addr(req_addr), .req_tag(req_tag),
      .ea_vld(ea_vld), .ea_addr(ea_addr),
      .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
      .rd_num(rd_num), .rd_data(rd_data),
      .cmd_single(cmd_single), .cmd_multi(cmd_multi),
      .mode_multi(mode_multi)
   );

   function automatic int ref_index(input int tag, input bit multi);
      int r;
      if (!multi) return xr[tag];
      r = 0;
      if (tag % 2 == 1)       r = r | xr[1];
      if ((tag / 2) % 2 == 1) r = r | xr[2];
      if (tag >= 4)           r = r | xr[4];
      return r;
   endfunction

   task automatic check(input string lbl, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", lbl, what, act, exp);
      end
   endtask

   // one clock: drive at the falling edge, check at the next falling edge
   task automatic cyc(input bit rv, input int ra, input int rt,
                      input bit we, input int wn, input int wd,
                      input int rn, input bit cs, input bit cm, input string lbl);
      req_vld = rv; req_addr = 15'(ra); req_tag = 3'(rt);
      wr_en = we; wr_num = 3'(wn); wr_data = 15'(wd);
      rd_num = 3'(rn); cmd_single = cs; cmd_multi = cm;
      m_vld = rv;
      if (rv) m_ea = (ra - ref_index(rt, m_multi)) & 32'h7fff;
      if (we && wn != 0) xr[wn] = wd & 32'h7fff;
      if (cs && !cm) m_multi = 1'b0;
      else if (cm && !cs) m_multi = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(lbl, "ea_vld", int'(ea_vld), int'(m_vld));
      check(lbl, "ea_addr", int'(ea_addr), m_ea);
      check(lbl, "mode_multi", int'(mode_multi), int'(m_multi));
      check(lbl, "rd_data", int'(rd_data), xr[rn]);
   endtask

   task automatic req(input int ra, input int rt, input string lbl);
      cyc(1'b1, ra, rt, 1'b0, 0, 0, rt, 1'b0, 1'b0, lbl);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      foreach (xr[i]) xr[i] = 0;
      m_multi = 1'b1; m_vld = 1'b0; m_ea = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, every register reads zero
      for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 0, 0, k, 0, 0, "R1");
      // R7: load all registers, read each back the next cycle
      for (int k = 1; k < 8; k++) begin
         cyc(0, 0, 0, 1, k, 32'h0111 * k + 32'h0003, 0, 0, 0, "R7");
         cyc(0, 0, 0, 0, 0, 0, k, 0, 0, "R7");
      end
      cyc(0, 0, 0, 1, 1, 32'h0013, 0, 0, 0, "R7");
      cyc(0, 0, 0, 1, 2, 32'h0140, 0, 0, 0, "R7");
      cyc(0, 0, 0, 1, 4, 32'h1205, 4, 0, 0, "R7");
      // R8: write to number 0 touches nothing
      cyc(0, 0, 0, 1, 0, 32'h7fff, 0, 0, 0, "R8");
      for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 0, 0, k, 0, 0, "R8");
      // R2: no-index pass-through in multiple-tag mode
      req(32'h5a5a, 0, "R2");
      // R4: single tag bits
      req(32'h4000, 1, "R4");
      req(32'h4000, 2, "R4");
      req(32'h4000, 4, "R4");
      // R5: OR of several registers
      req(32'h7000, 3, "R5");
      req(32'h7000, 5, "R5");
      req(32'h7000, 6, "R5");
      req(32'h7000, 7, "R5");
      // R10: idle cycles hold ea_addr and drop ea_vld
      cyc(0, 32'h1234, 3, 0, 0, 0, 0, 0, 0, "R10");
      cyc(0, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R10");
      // R9: enter single mode, both commands together hold
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, "R9");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
      // R2 in single mode, R3: each tag selects its own register
      req(32'h2222, 0, "R2");
      for (int k = 1; k < 8; k++) req(32'h7654, k, "R3");
      // R6: wrap below zero
      req(32'h0010, 7, "R6");
      req(32'h0000, 1, "R6");
      // R11: same-cycle write to selected register uses the old value
      cyc(1, 32'h3000, 5, 1, 5, 32'h0abc, 5, 0, 0, "R11");
      req(32'h3000, 5, "R11");
      // R11: same-cycle mode command; request still single mode
      cyc(1, 32'h6000, 3, 0, 0, 0, 3, 0, 1, "R11");
      req(32'h6000, 3, "R9");
      cyc(1, 32'h6000, 3, 0, 0, 0, 0, 1, 0, "R11");
      req(32'h6000, 3, "R3");
      // back-to-back requests
      req(32'h0100, 2, "R10");
      req(32'h0200, 6, "R10");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
      req(32'h0200, 6, "R5");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule